// File: doc/BRIEF.md
# Single-Cycle Two-Register Processor Core

The block is a 16-bit load-store processor core that runs one whole instruction per clock edge. The same cycle fetches the instruction word from an external asynchronous instruction store at the current program counter. The core then decodes the word, and the edge that ends the cycle updates the program counter, the two working registers (A and B) and the three status flags (carry C, negative N, zero Z). No pipeline sits between fetch, decode and execute.

Data memory sits outside the core on its own bus, separate from the instruction store. The core drives a 9-bit word address, a write strobe and a 16-bit write bus, and it takes read data back in the same cycle. A load therefore writes its register at the edge that ends the load cycle. An enable input freezes the whole core. Branches test the flags against a 3-bit pattern, and the test can be inverted.

Top module: `scpu_core`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the PC, A, B and all three flags to zero. While rst is high the store strobe stays low.
- R2: Load immediate (opcode 0 in bits [15:12]) writes the zero-extended byte in bits [7:0] into A when bit 8 is 0, or into B when bit 8 is 1. Flags are unchanged.
- R3: Load (opcode 1) and store (opcode 2) use bits [8:0] as the data address and bit 9 as the register select (0 = A, 1 = B). A load writes the read data into the register at that cycle's edge. A store raises dm_we_o for that cycle with the selected register on dm_wdata_o.
- R4: Add (3), subtract (4) and compare (11) compute A+B, A−B and A−B. Add and subtract write A, and compare writes no register. C is the adder carry-out, which on subtract and compare means no borrow. N is result bit 15, and Z is set when the result is zero.
- R5: Increment (5) writes B+1 into B and sets the flags as add does. Exchange (10) swaps A and B. Move (12) copies A into B. Exchange and move leave the flags unchanged.
- R6: OR (6), AND (7) and XOR (8) write A op B into A and clear C. Shift right (9) writes A>>1 into A, with C taking the bit shifted out. All four set N and Z from the result.
- R7: Set-flags (13) sets C, N and Z. Clear-flags (14) clears all three.
- R8: Branch (opcode 15) holds a condition in bits [11:8]: bit 11 is an invert bit, and the pattern is bit 10 for C, bit 9 for N and bit 8 for Z. With bit 11 at 0, the branch is taken only when all three flags equal the pattern.
- R9: With bit 11 at 1, the branch is taken when at least one flag differs from its pattern bit, and is not taken when all three match.
- R10: The condition values 4'b0000 and 4'b1111 both branch unconditionally.
- R11: A taken branch loads the PC with bits [7:0]. Every other enabled edge, including an untaken branch, advances the PC by one.
- R12: While en is low the PC, A, B and the flags hold their values and dm_we_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute enable; low freezes the core |
| pc_o | output | 8 | Registered program counter to the instruction store |
| instr_i | input | 16 | Instruction word read at pc_o |
| dm_addr_o | output | 9 | Data memory word address |
| dm_we_o | output | 1 | Data memory write strobe |
| dm_wdata_o | output | 16 | Data memory write bus |
| dm_rdata_i | input | 16 | Data memory read bus, valid in the same cycle |

## Verification
The hold from enable can land in the same cycle as a store or a branch. That cycle must suppress the memory write, or the redirect of the PC, that the instruction would otherwise cause. The bench drops en while a store is the current instruction and checks that the strobe falls and memory keeps its old word. It then raises en and checks that the store completes with the register value that was held. The same is done on an unconditional branch, judged by the PC staying put until en returns.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

  localparam int IW = 16;

  typedef enum logic [3:0] {
    OP_LDI  = 4'd0,
    OP_LD   = 4'd1,
    OP_ST   = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_INC  = 4'd5,
    OP_OR   = 4'd6,
    OP_AND  = 4'd7,
    OP_XOR  = 4'd8,
    OP_SHR  = 4'd9,
    OP_XCH  = 4'd10,
    OP_CMP  = 4'd11,
    OP_MOV  = 4'd12,
    OP_SETF = 4'd13,
    OP_CLRF = 4'd14,
    OP_BR   = 4'd15
  } op_e;

  // where a register's next value comes from
  typedef enum logic [2:0] {
    RS_KEEP,
    RS_ALU,
    RS_PEER,
    RS_MEM,
    RS_IMM
  } rsel_e;

  typedef enum logic [1:0] {
    FL_KEEP,
    FL_ALU,
    FL_SET,
    FL_CLR
  } fsel_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
  } flags_t;

  typedef struct packed {
    op_e   op;
    rsel_e a_sel;
    rsel_e b_sel;
    fsel_e f_sel;
    logic  st;
    logic  br;
  } ctrl_t;

endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ctrl_t         ctrl
);

  op_e op;
  assign op = op_e'(instr[15:12]);

  always_comb begin
    ctrl       = '0;
    ctrl.op    = op;
    ctrl.a_sel = RS_KEEP;
    ctrl.b_sel = RS_KEEP;
    ctrl.f_sel = FL_KEEP;
    case (op)
      OP_LDI: begin
        if (instr[8]) ctrl.b_sel = RS_IMM;
        else          ctrl.a_sel = RS_IMM;
      end
      OP_LD: begin
        if (instr[9]) ctrl.b_sel = RS_MEM;
        else          ctrl.a_sel = RS_MEM;
      end
      OP_ST: ctrl.st = 1'b1;
      OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR, OP_SHR: begin
        ctrl.a_sel = RS_ALU;
        ctrl.f_sel = FL_ALU;
      end
      OP_INC: begin
        ctrl.b_sel = RS_ALU;
        ctrl.f_sel = FL_ALU;
      end
      OP_CMP:  ctrl.f_sel = FL_ALU;
      OP_XCH: begin
        ctrl.a_sel = RS_PEER;
        ctrl.b_sel = RS_PEER;
      end
      OP_MOV:  ctrl.b_sel = RS_PEER;
      OP_SETF: ctrl.f_sel = FL_SET;
      OP_CLRF: ctrl.f_sel = FL_CLR;
      OP_BR:   ctrl.br = 1'b1;
      default: ctrl.br = 1'b0;
    endcase
  end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output flags_t        fl
);

  logic [DW:0] sum;
  logic        cout;

  always_comb begin
    sum  = '0;
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_ADD: begin
        sum  = {1'b0, a} + {1'b0, b};
        res  = sum[DW-1:0];
        cout = sum[DW];
      end
      OP_SUB, OP_CMP: begin
        sum  = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
        res  = sum[DW-1:0];
        cout = sum[DW];
      end
      OP_INC: begin
        sum  = {1'b0, b} + {{DW{1'b0}}, 1'b1};
        res  = sum[DW-1:0];
        cout = sum[DW];
      end
      OP_OR:  res = a | b;
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_SHR: begin
        res  = a >> 1;
        cout = a[0];
      end
      default: res = a;
    endcase
    fl.c = cout;
    fl.n = res[DW-1];
    fl.z = (res == '0);
  end

endmodule

// File: rtl/scpu_branch.sv
module scpu_branch
  import scpu_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     fl,
  output logic       take
);

  logic [2:0] pat;
  logic       all_eq;

  assign pat    = cond[2:0];
  assign all_eq = (fl == flags_t'(pat));

  always_comb begin
    if (cond == 4'b0000 || cond == 4'b1111) take = 1'b1;
    else if (cond[3])                       take = !all_eq;
    else                                    take = all_eq;
  end

endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int IAW = 8,
  parameter int DAW = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [IAW-1:0] pc_o,
  input  logic [IW-1:0]  instr_i,
  output logic [DAW-1:0] dm_addr_o,
  output logic           dm_we_o,
  output logic [DW-1:0]  dm_wdata_o,
  input  logic [DW-1:0]  dm_rdata_i
);

  localparam int IMMW = 8;

  ctrl_t           ctrl;
  logic [DW-1:0]   reg_a, reg_b, a_nxt, b_nxt, alu_res, imm;
  flags_t          flags, f_nxt, alu_fl;
  logic            take;
  logic [IAW-1:0]  pc_nxt;

  scpu_decode u_dec (
    .instr (instr_i),
    .ctrl  (ctrl)
  );

  scpu_alu #(.DW(DW)) u_alu (
    .op  (ctrl.op),
    .a   (reg_a),
    .b   (reg_b),
    .res (alu_res),
    .fl  (alu_fl)
  );

  scpu_branch u_br (
    .cond (instr_i[11:8]),
    .fl   (flags),
    .take (take)
  );

  assign imm        = {{(DW-IMMW){1'b0}}, instr_i[IMMW-1:0]};
  assign dm_addr_o  = instr_i[DAW-1:0];
  assign dm_wdata_o = instr_i[9] ? reg_b : reg_a;
  assign dm_we_o    = ctrl.st && en && !rst;

  always_comb begin
    case (ctrl.a_sel)
      RS_ALU:  a_nxt = alu_res;
      RS_PEER: a_nxt = reg_b;
      RS_MEM:  a_nxt = dm_rdata_i;
      RS_IMM:  a_nxt = imm;
      default: a_nxt = reg_a;
    endcase
    case (ctrl.b_sel)
      RS_ALU:  b_nxt = alu_res;
      RS_PEER: b_nxt = reg_a;
      RS_MEM:  b_nxt = dm_rdata_i;
      RS_IMM:  b_nxt = imm;
      default: b_nxt = reg_b;
    endcase
    case (ctrl.f_sel)
      FL_ALU:  f_nxt = alu_fl;
      FL_SET:  f_nxt = '1;
      FL_CLR:  f_nxt = '0;
      default: f_nxt = flags;
    endcase
    pc_nxt = (ctrl.br && take) ? instr_i[IAW-1:0] : pc_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o  <= '0;
      reg_a <= '0;
      reg_b <= '0;
      flags <= '0;
    end else if (en) begin
      pc_o  <= pc_nxt;
      reg_a <= a_nxt;
      reg_b <= b_nxt;
      flags <= f_nxt;
    end
  end

endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk #(
  parameter int IAW = 8,
  parameter int DAW = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [IAW-1:0] pc_o,
  input logic [15:0]    instr_i,
  input logic           dm_we_o,
  input logic [DAW-1:0] dm_addr_o
);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc_o == '0)); // R1

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !en |-> !dm_we_o); // R12

  AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_o)); // R12

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[15:12] != 4'hF) |=> (pc_o == $past(pc_o) + 1'b1)); // R11

  AST_BR_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[15:12] == 4'hF && (instr_i[11:8] == 4'h0 || instr_i[11:8] == 4'hF))
    |=> (pc_o == $past(instr_i[IAW-1:0]))); // R10

  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (instr_i[15:12] == 4'h2 && dm_addr_o == instr_i[DAW-1:0])); // R3

endmodule

bind scpu_core scpu_core_chk #(.IAW(IAW), .DAW(DAW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .pc_o      (pc_o),
  .instr_i   (instr_i),
  .dm_we_o   (dm_we_o),
  .dm_addr_o (dm_addr_o)
);

// File: tb/scpu_core_tb.sv
module scpu_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b1;
  logic [7:0]  pc;
  logic [15:0] instr;
  logic [8:0]  dm_addr;
  logic        dm_we;
  logic [15:0] dm_wdata, dm_rdata;

  logic [15:0] rom  [256];
  logic [15:0] dmem [512];
  logic        pl_we = 1'b0;
  logic [8:0]  pl_addr = '0;
  logic [15:0] pl_data = '0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign instr    = rom[pc];
  assign dm_rdata = dmem[dm_addr];

  always @(posedge clk) begin
    if (dm_we)      dmem[dm_addr] <= dm_wdata;
    else if (pl_we) dmem[pl_addr] <= pl_data;
  end

  scpu_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .pc_o       (pc),
    .instr_i    (instr),
    .dm_addr_o  (dm_addr),
    .dm_we_o    (dm_we),
    .dm_wdata_o (dm_wdata),
    .dm_rdata_i (dm_rdata)
  );

  // {op, A, B, expected A, expected B, expected {C,N,Z}}
  localparam logic [70:0] VECS [NV] = '{
    {4'd3,  16'h0001, 16'h0001, 16'h0002, 16'h0001, 3'b000},
    {4'd3,  16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 3'b101},
    {4'd3,  16'h7FFF, 16'h0001, 16'h8000, 16'h0001, 3'b010},
    {4'd4,  16'h0002, 16'h0001, 16'h0001, 16'h0001, 3'b100},
    {4'd4,  16'h0000, 16'h0002, 16'hFFFE, 16'h0002, 3'b010},
    {4'd4,  16'h0005, 16'h0005, 16'h0000, 16'h0005, 3'b101},
    {4'd5,  16'h1234, 16'hFFFF, 16'h1234, 16'h0000, 3'b101},
    {4'd6,  16'h00F0, 16'h0F00, 16'h0FF0, 16'h0F00, 3'b000},
    {4'd7,  16'h8F00, 16'hF0F0, 16'h8000, 16'hF0F0, 3'b010},
    {4'd8,  16'hAAAA, 16'hAAAA, 16'h0000, 16'hAAAA, 3'b001},
    {4'd9,  16'h0003, 16'h0007, 16'h0001, 16'h0007, 3'b100},
    {4'd9,  16'h8000, 16'h0007, 16'h4000, 16'h0007, 3'b000},
    {4'd10, 16'h1111, 16'h2222, 16'h2222, 16'h1111, 3'b000},
    {4'd11, 16'h0003, 16'h0005, 16'h0003, 16'h0005, 3'b010},
    {4'd12, 16'hBEEF, 16'h0000, 16'hBEEF, 16'hBEEF, 3'b000},
    {4'd14, 16'h0001, 16'h0002, 16'h0001, 16'h0002, 3'b000},
    {4'd13, 16'h0001, 16'h0002, 16'h0001, 16'h0002, 3'b111}
  };

  function automatic logic [15:0] e_ldi(input logic sel, input logic [7:0] v);
    return {4'h0, 3'b000, sel, v};
  endfunction
  function automatic logic [15:0] e_ld(input logic sel, input logic [8:0] ad);
    return {4'h1, 2'b00, sel, ad};
  endfunction
  function automatic logic [15:0] e_st(input logic sel, input logic [8:0] ad);
    return {4'h2, 2'b00, sel, ad};
  endfunction
  function automatic logic [15:0] e_br(input logic [3:0] cnd, input logic [7:0] t);
    return {4'hF, cnd, t};
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd3, 4'd4, 4'd11: return "R4";
      4'd5, 4'd10, 4'd12: return "R5";
      4'd13, 4'd14: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [8:0] ad, input logic [15:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = ad; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = e_br(4'h0, 8'h80);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_run(input int ncyc);
    @(negedge clk);
    rst = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [70:0] v;
    logic [2:0]  ef;
    logic [7:0]  exp_pc [8];
    string       pc_tag [8];
    clear_rom();
    for (int i = 0; i < 512; i++) dmem[i] = '0;
    repeat (2) @(negedge clk);

    // Table of ALU / register-move / flag operations
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      ef = v[2:0];
      hold_reset();
      clear_rom();
      poke(9'h100, v[66:51]);
      poke(9'h101, v[50:35]);
      poke(9'h102, 16'h0);
      poke(9'h103, 16'h0);
      rom[0] = e_ld(1'b0, 9'h100);
      rom[1] = e_ld(1'b1, 9'h101);
      rom[2] = {v[70:67], 12'h000};
      rom[3] = (ef != 3'b000) ? e_br({1'b0, ef}, 8'h40) : e_br(4'b1000, 8'h80);
      rom[4] = (ef != 3'b000) ? e_br(4'h0, 8'h80) : e_br(4'h0, 8'h40);
      rom[8'h40] = e_st(1'b0, 9'h102);
      rom[8'h41] = e_st(1'b1, 9'h103);
      rom[8'h42] = e_br(4'h0, 8'h42);
      release_run(10);
      chk({op_tag(v[70:67]), " A result"}, dmem[9'h102], v[34:19]);
      chk({op_tag(v[70:67]), " B result"}, dmem[9'h103], v[18:3]);
      chk({op_tag(v[70:67]), " flags via branch"}, {8'h0, pc}, 16'h0042);
    end

    // R1: reset after the set-flags vector left A=1, B=2, flags=111
    @(negedge clk);
    rst = 1'b1;
    clear_rom();
    rom[0] = e_st(1'b0, 9'h010);
    rom[1] = e_st(1'b1, 9'h011);
    rom[2] = e_br(4'b1000, 8'h80);
    rom[3] = e_br(4'h0, 8'h40);
    rom[8'h40] = e_br(4'h0, 8'h40);
    poke(9'h010, 16'hDEAD);
    poke(9'h011, 16'hDEAD);
    chk("R1 pc in reset", {8'h0, pc}, 16'h0000);
    chk("R1 no store in reset", {15'h0, dm_we}, 16'h0000);
    release_run(6);
    chk("R1 A cleared", dmem[9'h010], 16'h0000);
    chk("R1 B cleared", dmem[9'h011], 16'h0000);
    chk("R1 flags cleared", {8'h0, pc}, 16'h0040);

    // R2 / R3: immediates, register selects, 9-bit addresses
    hold_reset();
    clear_rom();
    poke(9'h1F0, 16'hCAFE);
    rom[0] = e_ldi(1'b0, 8'hA5);
    rom[1] = e_ldi(1'b1, 8'h3C);
    rom[2] = e_st(1'b0, 9'h1FF);
    rom[3] = e_st(1'b1, 9'h0FF);
    rom[4] = e_ld(1'b0, 9'h1F0);
    rom[5] = e_st(1'b0, 9'h100);
    rom[6] = e_br(4'h0, 8'h06);
    release_run(9);
    chk("R2 immediate into A", dmem[9'h1FF], 16'h00A5);
    chk("R2 immediate into B", dmem[9'h0FF], 16'h003C);
    chk("R3 load from high address", dmem[9'h100], 16'hCAFE);

    // R8-R11: branch rule walk, flags 101 from B=FFFF incremented
    hold_reset();
    clear_rom();
    poke(9'h100, 16'hFFFF);
    rom[0] = e_ld(1'b1, 9'h100);
    rom[1] = {4'd5, 12'h000};
    rom[2] = e_br(4'b0100, 8'h80);
    rom[3] = e_br(4'b1101, 8'h80);
    rom[4] = e_br(4'b1001, 8'h10);
    rom[8'h10] = e_br(4'b1111, 8'h20);
    rom[8'h20] = e_br(4'b0101, 8'h30);
    rom[8'h30] = e_br(4'b0000, 8'h30);
    exp_pc = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h20, 8'h30, 8'h30};
    pc_tag = '{"R11 step", "R11 step", "R8 mismatch not taken", "R9 all match not taken",
               "R9 one differs taken", "R10 cond 1111", "R8 exact taken", "R10 cond 0000"};
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      chk(pc_tag[s], {8'h0, pc}, {8'h0, exp_pc[s]});
    end

    // R12: enable low over a store and over a branch
    hold_reset();
    clear_rom();
    poke(9'h020, 16'h5555);
    rom[0] = e_ldi(1'b0, 8'h07);
    rom[1] = e_st(1'b0, 9'h020);
    rom[2] = e_br(4'h0, 8'h50);
    rom[8'h50] = e_br(4'h0, 8'h50);
    release_run(1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 pc held at store", {8'h0, pc}, 16'h0001);
    chk("R12 strobe low", {15'h0, dm_we}, 16'h0000);
    chk("R12 memory untouched", dmem[9'h020], 16'h5555);
    en = 1'b1;
    @(negedge clk);
    chk("R12 store after hold", dmem[9'h020], 16'h0007);
    chk("R12 pc resumes", {8'h0, pc}, 16'h0002);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 branch held", {8'h0, pc}, 16'h0002);
    en = 1'b1;
    @(negedge clk);
    chk("R12 branch after hold", {8'h0, pc}, 16'h0050);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule